// File: doc/BRIEF.md
# Clock Fan-out Enable Controller

This block holds the control logic that sits beside an eight-way clock fan-out. Every input and output is synchronous to the reference clock. Each reference cycle it produces one clock-enable bit per output. A bit is high in every reference cycle in which that output should emit a pulse. The block also produces a core clock enable that either stays high or marks every other cycle, and a lock flag that stays set once the PLL has reported lock.

Two global controls can shut the outputs off: a stop pin and a power-down pin. A single polarity pin flips the active sense of the eight per-output enables, the stop pin and the power-down pin together. The divide-select pin is not affected by the polarity pin. Changes to the per-output enables reach a gated output only on a low phase of the core clock enable, so a high phase that has started is never cut short. All interfaces are plain control and status levels. There is no streaming data path, so no valid/ready handshake and no back-pressure.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: With polarity 0, full rate and no stop or power-down, bit i of `out_en` equals bit i of `oe_pin` sampled at the previous rising clock edge. An enable pin at 1 means the output is on.
- R2: When `pol_inv` is 1, the sense of `oe_pin`, `halt_pin` and `sleep_pin` is inverted. An enable pin at 0 then means on, and stop and power-down become active high.
- R3: While stop is active (`halt_pin` = 0 at polarity 0), every bit of `out_en` is 0 from the next cycle on, whatever `oe_pin` holds.
- R4: While power-down is active (`sleep_pin` = 0 at polarity 0), every bit of `out_en` is 0 from the next cycle on. This takes priority over stop and over the per-output enables.
- R5: With `half_sel_n` = 1, `core_ce` is 1 in every cycle. With `half_sel_n` = 0, `core_ce` alternates between 1 and 0 from cycle to cycle.
- R6: `lock_flag` becomes 1 in the cycle after a rising edge samples `pll_locked` = 1, and it stays 1 after `pll_locked` falls.
- R7: Active power-down clears `lock_flag` at the next edge and holds it at 0 even while `pll_locked` is 1. Clearing wins over setting.
- R8: In half-rate mode, the registered per-output enable state changes only at edges where `core_ce` was 0.
- R9: No bit of `out_en` is 1 in a cycle where `core_ce` is 0.
- R10: In the first cycle after half-rate mode is entered, `core_ce` is 0. In the cycle after that it is 1, so the first enabled phase is a full high phase.
- R11: While `rst_n` is 0, `out_en` is all zeros and `lock_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| oe_pin | input | NUM_OUT | Per-output enable pins (sense set by `pol_inv`) |
| halt_pin | input | 1 | Stop pin, active low at polarity 0 |
| sleep_pin | input | 1 | Power-down pin, active low at polarity 0 |
| half_sel_n | input | 1 | Divide-by-two select, active low |
| pol_inv | input | 1 | Polarity flip for enable, stop and power-down pins |
| pll_locked | input | 1 | Lock report from the PLL |
| out_en | output | NUM_OUT | Gated clock enable per output |
| core_ce | output | 1 | Core clock enable, full or half rate |
| lock_flag | output | 1 | Sticky lock indicator |

## Verification
The assertions assume that every control pin is a clean level in the reference domain that changes only between edges, and that `half_sel_n` stays fixed for at least two cycles at a time. The alternation and first-high checks rely on that. The stimulus changes pins only on the falling clock edge. It holds each rate setting for several cycles, and it flips polarity only together with a fresh set of pin levels, whose effective meaning is stated in each step.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef struct packed {
    logic stop;
    logic pdown;
    logic half;
  } glob_ctl_t;
endpackage

// File: rtl/ctrl_pin_decode.sv
module ctrl_pin_decode #(
  parameter int NUM_OUT = 8
) (
  input  logic [NUM_OUT-1:0]     oe_pin,
  input  logic                   halt_pin,
  input  logic                   sleep_pin,
  input  logic                   half_sel_n,
  input  logic                   pol_inv,
  output logic [NUM_OUT-1:0]     want_on,
  output clkgate_pkg::glob_ctl_t ctl
);
  logic [NUM_OUT-1:0] oe_eff;

  // Polarity applies per bit to the enables and to the two shut-off pins.
  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_pol
      assign oe_eff[g] = oe_pin[g] ^ pol_inv;
    end
  endgenerate

  always_comb begin
    ctl.stop  = ~(halt_pin ^ pol_inv);
    ctl.pdown = ~(sleep_pin ^ pol_inv);
    ctl.half  = ~half_sel_n;
    // Power-down over stop over per-output enables.
    if (ctl.pdown)     want_on = '0;
    else if (ctl.stop) want_on = '0;
    else               want_on = oe_eff;
  end
endmodule

// File: rtl/ctrl_rate_div.sv
module ctrl_rate_div (
  input  logic clk,
  input  logic rst_n,
  input  logic half_mode,
  output logic core_ce
);
  logic div_q;

  // Held at 0 outside half mode, so the first toggle after entry is high.
  always_ff @(posedge clk) begin
    if (!rst_n)         div_q <= 1'b0;
    else if (half_mode) div_q <= ~div_q;
    else                div_q <= 1'b0;
  end

  assign core_ce = half_mode ? div_q : 1'b1;

  assert_half_alternates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode && core_ce) |=> (!half_mode || !core_ce));

  assert_first_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode && !$past(half_mode)) |=> (!half_mode || core_ce));
endmodule

// File: rtl/ctrl_gate_bank.sv
module ctrl_gate_bank #(
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] want_on,
  input  logic               kill,
  input  logic               half_mode,
  input  logic               core_ce,
  output logic [NUM_OUT-1:0] out_en
);
  logic [NUM_OUT-1:0] en_q;
  logic               low_edge;

  // Full rate: every edge closes a low phase. Half rate: only edges ending a low cycle.
  assign low_edge = !half_mode || !core_ce;

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n)        en_q[g] <= 1'b0;
        else if (low_edge) en_q[g] <= want_on[g];
      end
      assign out_en[g] = en_q[g] & core_ce;
    end
  endgenerate

  assert_kill_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && low_edge) |=> (en_q == '0));

  assert_low_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode && core_ce) |=> $stable(en_q));
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl #(
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] oe_pin,
  input  logic               halt_pin,
  input  logic               sleep_pin,
  input  logic               half_sel_n,
  input  logic               pol_inv,
  input  logic               pll_locked,
  output logic [NUM_OUT-1:0] out_en,
  output logic               core_ce,
  output logic               lock_flag
);
  import clkgate_pkg::*;

  glob_ctl_t          ctl;
  logic [NUM_OUT-1:0] want_on;

  ctrl_pin_decode #(.NUM_OUT(NUM_OUT)) u_decode (
    .oe_pin    (oe_pin),
    .halt_pin  (halt_pin),
    .sleep_pin (sleep_pin),
    .half_sel_n(half_sel_n),
    .pol_inv   (pol_inv),
    .want_on   (want_on),
    .ctl       (ctl)
  );

  ctrl_rate_div u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_mode(ctl.half),
    .core_ce  (core_ce)
  );

  ctrl_gate_bank #(.NUM_OUT(NUM_OUT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_on  (want_on),
    .kill     (ctl.stop | ctl.pdown),
    .half_mode(ctl.half),
    .core_ce  (core_ce),
    .out_en   (out_en)
  );

  // Sticky lock flag; power-down clears it and wins over a set.
  always_ff @(posedge clk) begin
    if (!rst_n)          lock_flag <= 1'b0;
    else if (ctl.pdown)  lock_flag <= 1'b0;
    else if (pll_locked) lock_flag <= 1'b1;
  end

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_flag && !ctl.pdown) |=> lock_flag);

  assert_lock_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pdown |=> !lock_flag);

  assert_gated_by_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ce |-> (out_en == '0));

  assert_pdown_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pdown && !ctl.half) |=> (out_en == '0));
endmodule

// File: tb/clkout_gate_ctrl_tb.sv
module clkout_gate_ctrl_tb;
  typedef struct {
    logic [7:0] en;
    logic       ce;
    logic       lk;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] oe_pin = 8'hFF;
  logic       halt_pin = 1'b1, sleep_pin = 1'b1, half_sel_n = 1'b1;
  logic       pol_inv = 1'b0, pll_locked = 1'b0;
  logic [7:0] out_en;
  logic       core_ce, lock_flag;

  int   checks = 0, failures = 0;
  exp_t sb_q[$];
  bit   done = 1'b0;

  always #10 clk = ~clk;

  clkout_gate_ctrl #(.NUM_OUT(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .halt_pin(halt_pin),
    .sleep_pin(sleep_pin), .half_sel_n(half_sel_n), .pol_inv(pol_inv),
    .pll_locked(pll_locked), .out_en(out_en), .core_ce(core_ce),
    .lock_flag(lock_flag)
  );

  // Monitor: pops one expected item per falling edge and compares.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (out_en !== e.en || core_ce !== e.ce || lock_flag !== e.lk) begin
        failures++;
        $display("FAIL %s: got en=%h ce=%b lk=%b expected en=%h ce=%b lk=%b",
                 e.tag, out_en, core_ce, lock_flag, e.en, e.ce, e.lk);
      end
    end
  end

  // Driver: set pins at the falling edge, push the expected result after the rising edge.
  task automatic step(input logic [7:0] oe, input logic halt, input logic sleep,
                      input logic half_n, input logic pol, input logic pll,
                      input logic [7:0] x_en, input logic x_ce, input logic x_lk,
                      input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    oe_pin = oe; halt_pin = halt; sleep_pin = sleep;
    half_sel_n = half_n; pol_inv = pol; pll_locked = pll;
    @(posedge clk);
    #1;
    e.en = x_en; e.ce = x_ce; e.lk = x_lk; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_en !== 8'h00 || lock_flag !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset: got en=%h lk=%b expected en=00 lk=0", out_en, lock_flag);
    end
    rst_n = 1'b1;
    //     oe     halt sleep hn pol pll   en    ce lk
    step(8'hFF, 1, 1, 1, 0, 0, 8'hFF, 1, 0, "R1 all on");
    step(8'hA5, 1, 1, 1, 0, 0, 8'hA5, 1, 0, "R1 pattern A5");
    step(8'h3C, 0, 0, 1, 1, 0, 8'hC3, 1, 0, "R2 inverted sense");
    step(8'h3C, 1, 0, 1, 1, 0, 8'h00, 1, 0, "R2 R3 inverted stop");
    step(8'hFF, 0, 1, 1, 0, 0, 8'h00, 1, 0, "R3 stop over enables");
    step(8'hFF, 1, 1, 1, 0, 0, 8'hFF, 1, 0, "R3 stop released");
    step(8'hFF, 1, 0, 1, 0, 0, 8'h00, 1, 0, "R4 power-down");
    step(8'hFF, 0, 0, 1, 0, 0, 8'h00, 1, 0, "R4 power-down with stop");
    step(8'hFF, 1, 1, 1, 0, 1, 8'hFF, 1, 1, "R6 lock set");
    step(8'hFF, 1, 1, 1, 0, 0, 8'hFF, 1, 1, "R6 lock held");
    step(8'hFF, 1, 0, 1, 0, 0, 8'h00, 1, 0, "R7 lock cleared");
    step(8'hFF, 1, 0, 1, 0, 1, 8'h00, 1, 0, "R7 clear wins over set");
    step(8'hFF, 1, 1, 1, 0, 0, 8'hFF, 1, 0, "R7 stays clear");
    step(8'hFF, 1, 1, 0, 0, 0, 8'hFF, 1, 0, "R10 R5 first half phase high");
    step(8'h0F, 1, 1, 0, 0, 0, 8'h00, 0, 0, "R9 R8 low phase gated");
    step(8'h0F, 1, 1, 0, 0, 0, 8'h0F, 1, 0, "R8 R5 update at low boundary");
    step(8'h0F, 1, 1, 0, 0, 0, 8'h00, 0, 0, "R9 R5 low again");
    step(8'h0F, 1, 1, 1, 0, 0, 8'h0F, 1, 0, "R5 full rate restored");
    step(8'h81, 1, 1, 1, 0, 0, 8'h81, 1, 0, "R1 pattern 81");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule